// File: doc/BRIEF.md
# Byte-Swapping IDE Register Bridge

This block sits between a big-endian memory-mapped bus and a little-endian ATA-style device register file. Every bus access carries an address, an access size (byte, half-word or word), a direction and write data. The bridge keeps the low 12 address bits and takes bits [11:4] as a register index. Each register therefore takes up 16 bytes of address space. The bridge then routes the access to one of three device interfaces: the taskfile registers, the device-control / alternate-status register, or the data port. Read data comes back in bus byte order.

A small device responder sits inside the top module. It stores the taskfile bytes, the device-control byte, a 32-bit data-port latch and an interrupt-pending flag, so the whole path can be observed at the ports. Requests enter on a valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Only reads produce a response. The response sits on `rsp_valid`/`rsp_rdata` and is held until a cycle with `rsp_ready` high. While a response is waiting and `rsp_ready` is low, `req_ready` is low and no new request is taken. Writes complete on the edge that accepts them.

Top module: `ide_bswap_bridge`

## Requirements
- R1: The register index is address bits [11:4]. Address bits above bit 11 and bits [3:0] have no effect on decoding, so 0x5060 selects index 6.
- R2: Byte accesses at index 1 to 6 write and read back the taskfile byte of that number. At index 7, a byte write stores the command byte, and a byte read returns the status byte. The status byte equals the last command byte written.
- R3: A byte write at index 8 or index 22 loads `dev_ctl` with write data bits [7:0]. A byte read at either index returns the status byte.
- R4: A byte read at any other index, including index 0, returns 0x000000FF. A byte write there changes no register.
- R5: Size codes are 0 byte, 1 half-word, 2 word and 3 reserved. Half-word and word accesses reach only index 0. Elsewhere, half-word reads return 0x0000FFFF and word reads return 0xFFFFFFFF. Reserved-size reads return 0xFFFFFFFF everywhere, and writes of these kinds are dropped.
- R6: Data-port writes store byte-swapped values. A half-word write replaces only latch bits [15:0] with swap16(wdata[15:0]). A word write stores swap32(wdata). Reads return swap16(latch[15:0]) zero-extended for a half-word and swap32(latch) for a word.
- R7: A pulse on `dev_irq_raise` sets `dev_irq`. A byte read of the status register at index 7 clears `dev_irq`. Alternate-status reads at index 8 or 22 leave it set. If a raise and a clearing read fall on the same cycle, the raise wins.
- R8: An accepted read raises `rsp_valid` on the next clock edge, with byte results zero-extended. Accepted writes never raise `rsp_valid`.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` holds its value and `req_ready` is low.
- R10: After reset, `rsp_valid`, `dev_ctl` and `dev_irq` are 0, `req_ready` is 1, and all taskfile bytes and the data latch are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_addr | input | AW (32) | Bus byte address |
| req_wdata | input | 32 | Write data, bus byte order |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, bus byte order |
| dev_irq_raise | input | 1 | Device requests an interrupt |
| dev_irq | output | 1 | Pending device interrupt |
| dev_ctl | output | 8 | Device-control byte |

## Verification
A read's data is due one edge after it is accepted. The bench drives each request on a falling edge and removes it on the next falling edge. It samples `rsp_valid` and `rsp_rdata` at that same falling edge, half a period after the accepting edge. `dev_ctl` and `dev_irq` are registered in the same edge as the accepted write, read or raise pulse, so they are checked at the next falling edge. Under back-pressure, the response is checked again on each later falling edge until the edge after `rsp_ready` returns high, where `rsp_valid` must have dropped.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_TASK = 2'd1,
    TGT_CTL  = 2'd2,
    TGT_DATA = 2'd3
  } tgt_e;

  localparam int OFS_W      = 12;
  localparam int STRIDE_LSB = 4;
  localparam int IDX_W      = OFS_W - STRIDE_LSB;
  localparam int TF_N       = 8;
  localparam int TF_SEL_W   = $clog2(TF_N);

  localparam logic [IDX_W-1:0] IDX_DATA  = 8'd0;
  localparam logic [IDX_W-1:0] IDX_TF_LO = 8'd1;
  localparam logic [IDX_W-1:0] IDX_TF_HI = 8'd7;
  localparam logic [IDX_W-1:0] IDX_CTL_A = 8'd8;
  localparam logic [IDX_W-1:0] IDX_CTL_B = 8'd22;
  localparam logic [TF_SEL_W-1:0] TF_STATUS = 3'd7;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] swap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/ide_reg_decode.sv
module ide_reg_decode
  import ide_bridge_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]       addr,
  input  acc_size_e           size,
  output tgt_e                tgt,
  output logic [TF_SEL_W-1:0] tf_sel
);

  logic [IDX_W-1:0] idx;

  assign idx    = addr[OFS_W-1:STRIDE_LSB];
  assign tf_sel = idx[TF_SEL_W-1:0];

  always_comb begin
    tgt = TGT_NONE;
    unique case (size)
      SZ_BYTE: begin
        if (idx >= IDX_TF_LO && idx <= IDX_TF_HI) tgt = TGT_TASK;
        else if (idx == IDX_CTL_A || idx == IDX_CTL_B) tgt = TGT_CTL;
      end
      SZ_HALF, SZ_WORD: begin
        if (idx == IDX_DATA) tgt = TGT_DATA;
      end
      default: tgt = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/ide_dev_model.sv
module ide_dev_model
  import ide_bridge_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  tgt_e                tgt,
  input  logic [TF_SEL_W-1:0] tf_sel,
  input  acc_size_e           size,
  input  logic [31:0]         wdata,
  input  logic                irq_raise,
  output logic [7:0]          rbyte,
  output logic [31:0]         rword,
  output logic [7:0]          ctl_q,
  output logic                irq_q
);

  logic [7:0]  tf_q [TF_N];
  logic [31:0] data_q;
  logic        status_rd;

  assign status_rd = rd_en && tgt == TGT_TASK && tf_sel == TF_STATUS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TF_N; i++) tf_q[i] <= '0;
      data_q <= '0;
      ctl_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en && tgt == TGT_TASK) tf_q[tf_sel] <= wdata[7:0];
      if (wr_en && tgt == TGT_CTL)  ctl_q <= wdata[7:0];
      if (wr_en && tgt == TGT_DATA) begin
        if (size == SZ_HALF) data_q[15:0] <= wdata[15:0];
        else                 data_q       <= wdata;
      end
      if (irq_raise)      irq_q <= 1'b1;
      else if (status_rd) irq_q <= 1'b0;
    end
  end

  assign rbyte = (tgt == TGT_CTL) ? tf_q[TF_STATUS] : tf_q[tf_sel];
  assign rword = data_q;

  a_r7_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd && !irq_raise |=> !irq_q);
  a_r7_alt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && tgt == TGT_CTL && irq_q |=> irq_q);

endmodule

// File: rtl/ide_bswap_bridge.sv
module ide_bswap_bridge
  import ide_bridge_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  input  logic          dev_irq_raise,
  output logic          dev_irq,
  output logic [7:0]    dev_ctl
);

  acc_size_e           size;
  tgt_e                tgt;
  logic [TF_SEL_W-1:0] tf_sel;
  logic                acc, dev_wr, dev_rd;
  logic [31:0]         dev_wdata, rd_word, rd_next;
  logic [7:0]          rd_byte;

  assign size      = acc_size_e'(req_size);
  assign req_ready = !(rsp_valid && !rsp_ready);
  assign acc       = req_valid && req_ready;
  assign dev_wr    = acc && req_write && tgt != TGT_NONE;
  assign dev_rd    = acc && !req_write && tgt != TGT_NONE;

  ide_reg_decode #(.AW(AW)) u_decode (
    .addr   (req_addr),
    .size   (size),
    .tgt    (tgt),
    .tf_sel (tf_sel)
  );

  always_comb begin
    if (size == SZ_HALF) dev_wdata = {16'h0, swap16(req_wdata[15:0])};
    else if (size == SZ_WORD) dev_wdata = swap32(req_wdata);
    else dev_wdata = {24'h0, req_wdata[7:0]};
  end

  ide_dev_model u_dev (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (dev_wr),
    .rd_en     (dev_rd),
    .tgt       (tgt),
    .tf_sel    (tf_sel),
    .size      (size),
    .wdata     (dev_wdata),
    .irq_raise (dev_irq_raise),
    .rbyte     (rd_byte),
    .rword     (rd_word),
    .ctl_q     (dev_ctl),
    .irq_q     (dev_irq)
  );

  always_comb begin
    unique case (tgt)
      TGT_TASK, TGT_CTL: rd_next = {24'h0, rd_byte};
      TGT_DATA: rd_next = (size == SZ_HALF) ? {16'h0, swap16(rd_word[15:0])}
                                             : swap32(rd_word);
      default: begin
        if (size == SZ_BYTE)      rd_next = 32'h0000_00FF;
        else if (size == SZ_HALF) rd_next = 32'h0000_FFFF;
        else                      rd_next = 32'hFFFF_FFFF;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  a_r8_rsp_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready && !req_write));
  a_r3_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr && tgt == TGT_CTL |=> dev_ctl == $past(req_wdata[7:0]));
  a_r5_data_idx0: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && tgt == TGT_DATA |-> req_addr[OFS_W-1:STRIDE_LSB] == IDX_DATA);

endmodule

// File: tb/ide_bswap_bridge_test.sv
module ide_bswap_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        dev_irq_raise = 1'b0;
  logic        req_ready, rsp_valid, dev_irq;
  logic [31:0] rsp_rdata;
  logic [7:0]  dev_ctl;
  int          checks = 0, errs = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ide_bswap_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .dev_irq_raise(dev_irq_raise), .dev_irq(dev_irq),
    .dev_ctl(dev_ctl)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 32'h010,  32'h5A,        32'h0,         8'd2},  // R2
    '{1'b0, 2'd0, 32'h010,  32'h0,         32'h5A,        8'd2},  // R2
    '{1'b1, 2'd0, 32'h060,  32'hC3,        32'h0,         8'd2},  // R2
    '{1'b0, 2'd0, 32'h5060, 32'h0,         32'hC3,        8'd1},  // R1 alias
    '{1'b1, 2'd0, 32'h070,  32'hA7,        32'h0,         8'd2},  // R2 command
    '{1'b0, 2'd0, 32'h070,  32'h0,         32'hA7,        8'd2},  // R2 status
    '{1'b0, 2'd0, 32'h080,  32'h0,         32'hA7,        8'd3},  // R3 alt
    '{1'b0, 2'd0, 32'h160,  32'h0,         32'hA7,        8'd3},  // R3 alt 22
    '{1'b1, 2'd0, 32'h080,  32'h06,        32'h0,         8'd3},  // R3 ctl
    '{1'b0, 2'd0, 32'h090,  32'h0,         32'hFF,        8'd4},  // R4
    '{1'b0, 2'd0, 32'h000,  32'h0,         32'hFF,        8'd4},  // R4 idx0
    '{1'b1, 2'd2, 32'h000,  32'h11223344,  32'h0,         8'd6},  // R6
    '{1'b0, 2'd2, 32'h000,  32'h0,         32'h11223344,  8'd6},  // R6
    '{1'b0, 2'd1, 32'h000,  32'h0,         32'h00001122,  8'd6},  // R6
    '{1'b1, 2'd1, 32'h000,  32'h0000AABB,  32'h0,         8'd6},  // R6
    '{1'b0, 2'd2, 32'h000,  32'h0,         32'hAABB3344,  8'd6},  // R6
    '{1'b1, 2'd0, 32'h000,  32'h99,        32'h0,         8'd4},  // R4
    '{1'b0, 2'd2, 32'h000,  32'h0,         32'hAABB3344,  8'd4},  // R4
    '{1'b1, 2'd2, 32'h010,  32'hDEADBEEF,  32'h0,         8'd5},  // R5
    '{1'b0, 2'd0, 32'h010,  32'h0,         32'h5A,        8'd5},  // R5
    '{1'b0, 2'd1, 32'h010,  32'h0,         32'h0000FFFF,  8'd5},  // R5
    '{1'b0, 2'd2, 32'h070,  32'h0,         32'hFFFFFFFF,  8'd5},  // R5
    '{1'b0, 2'd3, 32'h000,  32'h0,         32'hFFFFFFFF,  8'd5},  // R5
    '{1'b1, 2'd3, 32'h000,  32'h12345678,  32'h0,         8'd5},  // R5
    '{1'b0, 2'd2, 32'h000,  32'h0,         32'hAABB3344,  8'd5}   // R5
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(5 * 50000);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R10 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R10 dev_ctl", {24'h0, dev_ctl}, 32'h0);
    chk("R10 dev_irq", {31'h0, dev_irq}, 32'h0);
    access(1'b0, 2'd0, 32'h030, 32'h0);
    chk("R10 taskfile", rsp_rdata, 32'h0);
    access(1'b0, 2'd2, 32'h000, 32'h0);
    chk("R10 data latch", rsp_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      access(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd);
      if (VECS[i].wr) chk({tag, " R8 no rsp"}, {31'h0, rsp_valid}, 32'h0);
      else begin
        chk({tag, " R8 valid"}, {31'h0, rsp_valid}, 32'h1);
        chk(tag, rsp_rdata, VECS[i].exp);
      end
    end

    chk("R3 ctl idx8", {24'h0, dev_ctl}, 32'h06);
    access(1'b1, 2'd0, 32'h160, 32'h02);
    chk("R3 ctl idx22", {24'h0, dev_ctl}, 32'h02);

    @(negedge clk); dev_irq_raise = 1'b1;
    @(negedge clk); dev_irq_raise = 1'b0;
    chk("R7 raise", {31'h0, dev_irq}, 32'h1);
    access(1'b0, 2'd0, 32'h080, 32'h0);
    chk("R7 alt keeps", {31'h0, dev_irq}, 32'h1);
    access(1'b0, 2'd0, 32'h160, 32'h0);
    chk("R7 alt22 keeps", {31'h0, dev_irq}, 32'h1);
    access(1'b0, 2'd0, 32'h070, 32'h0);
    chk("R7 status clears", {31'h0, dev_irq}, 32'h0);

    @(negedge clk); rsp_ready = 1'b0;
    access(1'b0, 2'd0, 32'h010, 32'h0);
    chk("R9 valid", {31'h0, rsp_valid}, 32'h1);
    chk("R9 data", rsp_rdata, 32'h5A);
    chk("R9 not ready", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    chk("R9 still valid", {31'h0, rsp_valid}, 32'h1);
    chk("R9 data held", rsp_rdata, 32'h5A);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", {31'h0, rsp_valid}, 32'h0);
    chk("R9 ready again", {31'h0, req_ready}, 32'h1);

    done = 1'b1;
    finish_run();
  end

endmodule